// File: doc/BRIEF.md
# Exception Return Frame Unwinder

This block performs the return-from-exception sequence of a processor core. After a start pulse it reads a stacked exception frame from memory through a single read port. It reads the saved status word and then the saved program counter. When frame format words are in use, it also reads a format word. The top nibble of that word says how many further bytes belong to the frame, and the stack pointer is moved past them. The block then reports the final program counter, status word and stack pointer with a one-cycle done pulse.

One format code marks a throwaway frame. In that case the block hands the status word it has just read, together with the stack pointer that sits past the short frame, to the surrounding core. Applying that status word can change which stack pointer is active, so for exactly one cycle the block offers a select input. If the select is raised in that cycle, the unwind restarts at the supplied alternate stack pointer. If it is not raised, the unwind restarts at the advanced one. The process repeats until a frame that is not a throwaway frame completes it.

Top module: `frame_unwind`

## Requirements
- R1: While reset is low, and after it, the read request, done pulse, throwaway pulse and the pc, sr and sp outputs are all zero until the first run completes or hands over a throwaway frame.
- R2: Each frame is read in a fixed order. First a 16-bit status read at the current stack pointer (rd_long_o=0, value taken from rd_data_i[15:0]). Then a 32-bit program counter read at stack pointer + 2 (rd_long_o=1, all 32 bits taken).
- R3: When fmt_en_i is 0 at start, no format word is read, even if memory holds one. The run ends after the program counter read with sp_o equal to the start pointer + 6.
- R4: When fmt_en_i is 1 at start, a 16-bit format word is read at stack pointer + 6. The format code is rd_data_i[15:12]. Code 0 ends the run with sp_o equal to the frame start + 8.
- R5: Codes 2 and 3 add 4 bytes (frame start + 12). Code 4 adds 8 (frame start + 16). Code 7 adds 52 (frame start + 60).
- R6: Any code from 5, 6 or 8 to 15 adds no bytes and still completes normally at frame start + 8.
- R7: Code 1 raises tw_o for one cycle, with sr_o holding that frame's status word and sp_o holding the frame start + 8. A fresh status read then begins.
- R8: If sp_sel_i is 1 in the cycle tw_o is high, the next frame is read at sp_alt_i. Otherwise it is read at the frame start + 8.
- R9: A run ends with done_o high for exactly one cycle. At that point pc_o is the last program counter read, sr_o is the last status word read, and sp_o is the final stack pointer.
- R10: At most one read is outstanding. rd_valid_o, rd_addr_o and rd_long_o stay unchanged until rd_ready_i is seen, and read data is taken in the rd_ready_i cycle.
- R11: A start pulse while a run is in progress is ignored. A start pulse in the cycle done_o is high begins a new run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Begin an unwind (taken only when idle) |
| sp_i | input | AW | Stack pointer at start |
| fmt_en_i | input | 1 | Frames carry a format word |
| sp_sel_i | input | 1 | Replace stack pointer in the throwaway cycle |
| sp_alt_i | input | AW | Replacement stack pointer |
| rd_valid_o | output | 1 | Read request |
| rd_addr_o | output | AW | Read byte address |
| rd_long_o | output | 1 | 1 = 32-bit read, 0 = 16-bit read |
| rd_ready_i | input | 1 | Read accepted, data valid this cycle |
| rd_data_i | input | 32 | Read data |
| pc_o | output | 32 | Restored program counter |
| sr_o | output | 16 | Restored or handed-over status word |
| sp_o | output | AW | Final or handed-over stack pointer |
| done_o | output | 1 | Unwind complete (one cycle) |
| tw_o | output | 1 | Throwaway frame handed over (one cycle) |

## Verification
Two events can share a cycle. The first is a throwaway hand-over with the stack pointer select. The bench answers tw_o in that same cycle, either with the select raised and an alternate pointer or with the select left low, and judges the result by the address of the next status read and the final stack pointer. The second is a done pulse together with a new start pulse. The driver raises start in the very cycle it sees done_o. The scoreboard then expects the new run's reads to begin immediately, and expects a start raised in mid-run to add neither reads nor results.

// File: rtl/unw_pkg.sv
// Shared definitions for the frame unwinder: state encoding, fixed data widths
// and the byte counts the frame layout imposes.
package unw_pkg;
    localparam int PC_W       = 32;
    localparam int SR_W       = 16;
    localparam int STEP_SR    = 2;
    localparam int STEP_PC    = 4;
    localparam int STEP_FMT   = 2;
    localparam int XTRA_SHORT = 4;
    localparam int XTRA_MID   = 8;
    localparam int XTRA_LONG  = 52;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SR,
        ST_PC,
        ST_FMT,
        ST_SEL,
        ST_FIN
    } unw_state_t;
endpackage

// File: rtl/unw_fmt_decode.sv
// Maps a frame format code to the number of extra bytes that follow the
// format word and flags the throwaway code. Purely combinational.
// Assumes: the code is bits 15:12 of the format word.
module unw_fmt_decode
    import unw_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic [3:0]    code_i,
    output logic [AW-1:0] extra_o,
    output logic          throw_o
);
    // Decode code to extra byte count; unknown codes add nothing.
    always_comb begin
        extra_o = '0;
        throw_o = 1'b0;
        case (code_i)
            4'd1:       throw_o = 1'b1;
            4'd2, 4'd3: extra_o = AW'(XTRA_SHORT);
            4'd4:       extra_o = AW'(XTRA_MID);
            4'd7:       extra_o = AW'(XTRA_LONG);
            default:    extra_o = '0;
        endcase
    end
endmodule

// File: rtl/unw_sp_reg.sv
// Working stack pointer of the unwinder. Loaded at start, advanced after each
// accepted read and optionally replaced in the throwaway select cycle.
// Assumes: at most one of the control inputs is active per cycle.
module unw_sp_reg #(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic [AW-1:0] load_val_i,
    input  logic          adv_i,
    input  logic [AW-1:0] adv_amt_i,
    input  logic          sel_cyc_i,
    input  logic          sel_i,
    input  logic [AW-1:0] alt_i,
    output logic [AW-1:0] sp_o
);
    // Update the working pointer from start, advance or replacement.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sp_o <= '0;
        end else if (load_i) begin
            sp_o <= load_val_i;
        end else if (adv_i) begin
            sp_o <= sp_o + adv_amt_i;
        end else if (sel_cyc_i && sel_i) begin
            sp_o <= alt_i;
        end
    end
endmodule

// File: rtl/frame_unwind.sv
// Return-from-exception frame unwinder. Reads status word, program counter
// and (optionally) a format word per frame, skips frame extension bytes and
// loops over throwaway frames. Assumes a memory port that returns data in the
// cycle it raises rd_ready_i; no bus error handling.
module frame_unwind
    import unw_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start_i,
    input  logic [AW-1:0]   sp_i,
    input  logic            fmt_en_i,
    input  logic            sp_sel_i,
    input  logic [AW-1:0]   sp_alt_i,
    output logic            rd_valid_o,
    output logic [AW-1:0]   rd_addr_o,
    output logic            rd_long_o,
    input  logic            rd_ready_i,
    input  logic [31:0]     rd_data_i,
    output logic [PC_W-1:0] pc_o,
    output logic [SR_W-1:0] sr_o,
    output logic [AW-1:0]   sp_o,
    output logic            done_o,
    output logic            tw_o
);
    unw_state_t      state_q, state_d;
    logic [AW-1:0]   sp_cur;
    logic [AW-1:0]   adv_amt;
    logic [AW-1:0]   extra;
    logic            throw;
    logic            acc;
    logic            fmt_en_q;
    logic [SR_W-1:0] sr_q;
    logic [PC_W-1:0] pc_q;

    unw_fmt_decode #(.AW(AW)) u_dec (
        .code_i  (rd_data_i[15:12]),
        .extra_o (extra),
        .throw_o (throw)
    );

    unw_sp_reg #(.AW(AW)) u_sp (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (state_q == ST_IDLE && start_i),
        .load_val_i (sp_i),
        .adv_i      (acc),
        .adv_amt_i  (adv_amt),
        .sel_cyc_i  (state_q == ST_SEL),
        .sel_i      (sp_sel_i),
        .alt_i      (sp_alt_i),
        .sp_o       (sp_cur)
    );

    // Drive the single read request from the current state.
    always_comb begin
        rd_valid_o = (state_q == ST_SR) || (state_q == ST_PC) || (state_q == ST_FMT);
        rd_long_o  = (state_q == ST_PC);
        rd_addr_o  = sp_cur;
        acc        = rd_valid_o && rd_ready_i;
    end

    // Pick the pointer advance for the read being accepted.
    always_comb begin
        case (state_q)
            ST_SR:   adv_amt = AW'(STEP_SR);
            ST_PC:   adv_amt = AW'(STEP_PC);
            ST_FMT:  adv_amt = AW'(STEP_FMT) + (throw ? '0 : extra);
            default: adv_amt = '0;
        endcase
    end

    // Next-state sequencing of the unwind.
    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_IDLE: if (start_i) state_d = ST_SR;
            ST_SR:   if (acc) state_d = ST_PC;
            ST_PC:   if (acc) state_d = fmt_en_q ? ST_FMT : ST_FIN;
            ST_FMT:  if (acc) state_d = throw ? ST_SEL : ST_FIN;
            ST_SEL:  state_d = ST_SR;
            ST_FIN:  state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // State register and captured frame fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            fmt_en_q <= 1'b0;
            sr_q     <= '0;
            pc_q     <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && start_i) fmt_en_q <= fmt_en_i;
            if (state_q == ST_SR && acc)       sr_q <= rd_data_i[SR_W-1:0];
            if (state_q == ST_PC && acc)       pc_q <= rd_data_i[PC_W-1:0];
        end
    end

    // Result registers and the done and throwaway pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_o   <= '0;
            sr_o   <= '0;
            sp_o   <= '0;
            done_o <= 1'b0;
            tw_o   <= 1'b0;
        end else begin
            done_o <= 1'b0;
            tw_o   <= 1'b0;
            if (state_q == ST_FMT && acc && throw) begin
                tw_o <= 1'b1;
                sr_o <= sr_q;
                sp_o <= sp_cur + AW'(STEP_FMT);
            end
            if (state_q == ST_FIN) begin
                done_o <= 1'b1;
                pc_o   <= pc_q;
                sr_o   <= sr_q;
                sp_o   <= sp_cur;
            end
        end
    end

    AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid_o && !rd_ready_i |=> rd_valid_o && $stable(rd_addr_o) && $stable(rd_long_o)); // R10
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R9
    AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !rd_valid_o && !tw_o); // R9
    AST_TW_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        tw_o |-> !rd_valid_o && !done_o); // R7
    AST_TW_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        tw_o |=> rd_valid_o && !rd_long_o); // R7
    AST_SEL_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        tw_o && sp_sel_i |=> rd_addr_o == $past(sp_alt_i)); // R8
endmodule

// File: tb/frame_unwind_test.sv
// Scoreboard bench: driver tasks queue expected reads and results, the
// memory responder and the output monitor pop and compare them.
module frame_unwind_test;
    localparam int AW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic [AW-1:0] sp_i = '0;
    logic          fmt_en_i = 1'b0;
    logic          sp_sel_i = 1'b0;
    logic [AW-1:0] sp_alt_i = '0;
    logic          rd_valid_o;
    logic [AW-1:0] rd_addr_o;
    logic          rd_long_o;
    logic          rd_ready_i = 1'b0;
    logic [31:0]   rd_data_i = '0;
    logic [31:0]   pc_o;
    logic [15:0]   sr_o;
    logic [AW-1:0] sp_o;
    logic          done_o;
    logic          tw_o;

    int checks = 0;
    int errors = 0;

    logic [15:0] mem [logic [31:0]];
    logic [32:0] exp_rd [$];
    logic [79:0] exp_done [$];
    logic [47:0] exp_tw [$];
    logic        sel_plan = 1'b0;
    logic [31:0] alt_plan = '0;

    frame_unwind #(.AW(AW)) uut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .sp_i(sp_i),
        .fmt_en_i(fmt_en_i), .sp_sel_i(sp_sel_i), .sp_alt_i(sp_alt_i),
        .rd_valid_o(rd_valid_o), .rd_addr_o(rd_addr_o), .rd_long_o(rd_long_o),
        .rd_ready_i(rd_ready_i), .rd_data_i(rd_data_i),
        .pc_o(pc_o), .sr_o(sr_o), .sp_o(sp_o), .done_o(done_o), .tw_o(tw_o)
    );

    always #2 clk = ~clk;

    function automatic logic [15:0] mrd(input logic [31:0] a);
        return mem.exists(a) ? mem[a] : 16'h0000;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [79:0] act, input logic [79:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic put_frame(input logic [31:0] a, input logic [15:0] sr,
                             input logic [31:0] pc, input logic [15:0] fw);
        mem[a] = sr; mem[a+2] = pc[31:16]; mem[a+4] = pc[15:0]; mem[a+6] = fw;
    endtask

    // Queue the reads one frame produces (R2, R4).
    task automatic exp_frame(input logic [31:0] a, input bit fe);
        exp_rd.push_back({a, 1'b0});
        exp_rd.push_back({a + 32'd2, 1'b1});
        if (fe) exp_rd.push_back({a + 32'd6, 1'b0});
    endtask

    task automatic exp_result(input logic [31:0] pc, input logic [15:0] sr, input logic [31:0] sp);
        exp_done.push_back({pc, sr, sp});
    endtask

    task automatic launch(input logic [31:0] sp, input bit fe);
        sp_i = sp; fmt_en_i = fe; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic wait_done();
        while (!done_o) @(negedge clk);
    endtask

    // Memory responder with varying latency; checks address order and hold.
    int          wait_left = 0;
    int          rd_seq = 0;
    bit          was_wait = 1'b0;
    logic [32:0] held = '0;
    always @(negedge clk) begin
        rd_ready_i = 1'b0;
        if (rst_n && rd_valid_o) begin
            if (was_wait)
                chk({rd_addr_o, rd_long_o} == held, "R10 hold", 80'({rd_addr_o, rd_long_o}), 80'(held));
            if (wait_left > 0) begin
                wait_left--;
                was_wait = 1'b1;
                held = {rd_addr_o, rd_long_o};
            end else begin
                was_wait = 1'b0;
                rd_ready_i = 1'b1;
                rd_data_i = rd_long_o ? {mrd(rd_addr_o), mrd(rd_addr_o + 32'd2)}
                                      : {16'hDEAD, mrd(rd_addr_o)};
                if (exp_rd.size() == 0)
                    chk(1'b0, "R2/R11 unexpected read", 80'({rd_addr_o, rd_long_o}), 80'd0);
                else begin
                    logic [32:0] e;
                    e = exp_rd.pop_front();
                    chk({rd_addr_o, rd_long_o} == e, "R2 read addr/size", 80'({rd_addr_o, rd_long_o}), 80'(e));
                end
                wait_left = (rd_seq * 5) % 3;
                rd_seq++;
            end
        end
    end

    // Answer the throwaway hand-over with the planned select (R8).
    always @(negedge clk) begin
        sp_sel_i = tw_o ? sel_plan : 1'b0;
        sp_alt_i = alt_plan;
    end

    // Output monitor: compare done results and throwaway hand-overs.
    always @(negedge clk) begin
        if (rst_n && done_o) begin
            if (exp_done.size() == 0) chk(1'b0, "R9 unexpected done", 80'({pc_o, sr_o, sp_o}), 80'd0);
            else begin
                logic [79:0] e;
                e = exp_done.pop_front();
                chk({pc_o, sr_o, sp_o} == e, "R9 result pc/sr/sp", {pc_o, sr_o, sp_o}, e);
            end
        end
        if (rst_n && tw_o) begin
            if (exp_tw.size() == 0) chk(1'b0, "R7 unexpected throwaway", 80'({sr_o, sp_o}), 80'd0);
            else begin
                logic [47:0] e;
                e = exp_tw.pop_front();
                chk({sr_o, sp_o} == e, "R7 throwaway sr/sp", 80'({sr_o, sp_o}), 80'(e));
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(!rd_valid_o && !done_o && !tw_o && pc_o == 0 && sr_o == 0 && sp_o == 0,
            "R1 reset state", 80'({rd_valid_o, done_o, tw_o, pc_o, sr_o}), 80'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!rd_valid_o && !done_o && sp_o == 0, "R1 idle after reset",
            80'({rd_valid_o, done_o, sp_o}), 80'd0);

        put_frame(32'h1000, 16'h2700, 32'h00C0FFEE, 16'h1000);
        put_frame(32'h1100, 16'h2001, 32'h00001100, 16'h0000);
        put_frame(32'h1200, 16'h2002, 32'h00001200, 16'h2008);
        put_frame(32'h1300, 16'h2003, 32'h00001300, 16'h3000);
        put_frame(32'h1400, 16'h2004, 32'h00001400, 16'h4000);
        put_frame(32'h1500, 16'h2005, 32'h00001500, 16'h7000);
        put_frame(32'h1600, 16'h2006, 32'h00001600, 16'h5000);
        put_frame(32'h1700, 16'h2007, 32'h00001700, 16'hF123);
        put_frame(32'h3000, 16'h3704, 32'h11111111, 16'h1000);
        put_frame(32'h3008, 16'h2010, 32'h22222222, 16'h0000);
        put_frame(32'h4000, 16'h3000, 32'h00000033, 16'h1000);
        put_frame(32'h5000, 16'h0700, 32'h00000044, 16'h4000);

        // R3: no format word, even though memory holds code 1 there.
        exp_frame(32'h1000, 1'b0); exp_result(32'h00C0FFEE, 16'h2700, 32'h1006);
        launch(32'h1000, 1'b0); wait_done();
        // R4: code 0; started in the done cycle (R11).
        exp_frame(32'h1100, 1'b1); exp_result(32'h1100, 16'h2001, 32'h1108);
        launch(32'h1100, 1'b1); wait_done();
        // R5: codes 2, 3, 4, 7.
        exp_frame(32'h1200, 1'b1); exp_result(32'h1200, 16'h2002, 32'h120C);
        launch(32'h1200, 1'b1); wait_done();
        exp_frame(32'h1300, 1'b1); exp_result(32'h1300, 16'h2003, 32'h130C);
        launch(32'h1300, 1'b1); wait_done();
        exp_frame(32'h1400, 1'b1); exp_result(32'h1400, 16'h2004, 32'h1410);
        launch(32'h1400, 1'b1); wait_done();
        exp_frame(32'h1500, 1'b1); exp_result(32'h1500, 16'h2005, 32'h153C);
        launch(32'h1500, 1'b1); wait_done();
        // R6: unlisted codes 5 and 15.
        exp_frame(32'h1600, 1'b1); exp_result(32'h1600, 16'h2006, 32'h1608);
        launch(32'h1600, 1'b1); wait_done();
        exp_frame(32'h1700, 1'b1); exp_result(32'h1700, 16'h2007, 32'h1708);
        launch(32'h1700, 1'b1); wait_done();
        // R7 / R8: throwaway without select, restart at advanced pointer.
        sel_plan = 1'b0; alt_plan = 32'h9000;
        exp_frame(32'h3000, 1'b1); exp_frame(32'h3008, 1'b1);
        exp_tw.push_back({16'h3704, 32'h3008});
        exp_result(32'h22222222, 16'h2010, 32'h3010);
        launch(32'h3000, 1'b1); wait_done();
        // R8: throwaway with select, restart at the alternate pointer.
        sel_plan = 1'b1; alt_plan = 32'h5000;
        exp_frame(32'h4000, 1'b1); exp_frame(32'h5000, 1'b1);
        exp_tw.push_back({16'h3000, 32'h4008});
        exp_result(32'h00000044, 16'h0700, 32'h5010);
        launch(32'h4000, 1'b1); wait_done();
        sel_plan = 1'b0;
        // R11: start in mid-run is ignored.
        exp_frame(32'h1000, 1'b0); exp_result(32'h00C0FFEE, 16'h2700, 32'h1006);
        launch(32'h1000, 1'b0);
        @(negedge clk);
        sp_i = 32'h7000; fmt_en_i = 1'b1; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        wait_done();
        repeat (6) begin
            @(negedge clk);
            chk(!rd_valid_o, "R11 no read after ignored start", 80'(rd_valid_o), 80'd0);
        end
        chk(exp_rd.size() == 0 && exp_done.size() == 0 && exp_tw.size() == 0,
            "R9 scoreboard drained", 80'(exp_rd.size() + exp_done.size() + exp_tw.size()), 80'd0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule